// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a bank of edge-triggered registers that sits between a command source and a set of loads. On each rising clock edge it samples a parallel input word and presents the stored value on its outputs. A width-mode input picks one of two behaviours. In straight mode each of 25 input bits drives one output. In duplicate mode only the low 14 input bits are used, and each drives two output copies. In duplicate mode a layout input places the copies either as two stacked halves or as adjacent pairs.

Two chip-select inputs together form a freeze gate. While both are high the register bank keeps its contents, so the outputs stay still. An active-low reset clears the bank at once, without waiting for a clock edge, and it overrides the freeze gate. The mode and layout inputs are meant to be static. They are captured together with the data, so a change reaches the outputs only at a clock edge.

Top module: `fanout_reg`

## Requirements
- R1: The outputs change only after a rising clock edge. Input changes made between edges do not show on the outputs before the next edge.
- R2: With `dup_mode` low (straight mode), `q_out[24:0]` equals the input word captured at the last enabled edge, and `q_out[27:25]` is 0.
- R3: With `dup_mode` high and `arr_sel` low (stacked layout), `q_out[i]` and `q_out[i+14]` both equal captured input bit i, for i = 0..13.
- R4: With `dup_mode` high and `arr_sel` high (paired layout), `q_out[2i]` and `q_out[2i+1]` both equal captured input bit i, for i = 0..13.
- R5: `dup_mode` and `arr_sel` are sampled at the rising edge together with the data. Changing them between edges leaves the outputs unchanged until the next enabled edge.
- R6: Driving `rst_n` low forces every output to 0 at once, including in the middle of a clock cycle with no edge.
- R7: While `cs_a` and `cs_b` are both high at an edge, that edge leaves the outputs unchanged. New data, mode and layout are all ignored.
- R8: If either chip select is low at an edge, the edge captures normally. With `cs_b` held low, every edge captures whatever the value of `cs_a`.
- R9: Reset takes priority over the freeze gate. With both chip selects high, `rst_n` low still clears the outputs, and they stay 0 while reset is held.
- R10: After `rst_n` rises, with the data inputs at 0 and the clock running, the outputs stay at 0 at every edge and between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dup_mode | input | 1 | 0 = 25-bit straight mode, 1 = 14-bit duplicate mode |
| arr_sel | input | 1 | Duplicate layout: 0 = stacked halves, 1 = adjacent pairs |
| cs_a | input | 1 | Freeze gate select, first input |
| cs_b | input | 1 | Freeze gate select, second input; tie low to disable freezing |
| d_in | input | 25 | Parallel data word |
| q_out | output | 28 | Registered, mapped outputs |

## Verification
The block has no state other than the stored word and the two stored configuration bits. Any fault in them shows up directly on `q_out` one edge after the stimulus that should have set them. A freeze gate that leaks shows up as an output change on the first frozen edge that carries different data or a different mode. A layout mix-up shows up as a wrong copy position as soon as the captured word has unequal bits in its low 14 positions. Reset faults show up within a few nanoseconds of `rst_n` falling, without any clock edge.

// File: rtl/fanout_reg.sv
module fanout_reg #(
  parameter int DW = 25,
  parameter int NW = 14,
  localparam int OW = (2 * NW > DW) ? 2 * NW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dup_mode,
  input  logic          arr_sel,
  input  logic          cs_a,
  input  logic          cs_b,
  input  logic [DW-1:0] d_in,
  output logic [OW-1:0] q_out
);

  logic [DW-1:0] data_q;
  logic          dup_q;
  logic          arr_q;
  logic          hold;

  assign hold = cs_a & cs_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dup_q  <= 1'b0;
      arr_q  <= 1'b0;
    end else if (!hold) begin
      data_q <= d_in;
      dup_q  <= dup_mode;
      arr_q  <= arr_sel;
    end
  end

  logic [OW-1:0] map_one;
  logic [OW-1:0] map_a;
  logic [OW-1:0] map_b;

  assign map_one = OW'(data_q);
  assign map_a   = OW'({data_q[NW-1:0], data_q[NW-1:0]});

  for (genvar i = 0; i < NW; i++) begin : g_pair
    assign map_b[2*i]   = data_q[i];
    assign map_b[2*i+1] = data_q[i];
  end
  if (OW > 2 * NW) begin : g_pad
    assign map_b[OW-1:2*NW] = '0;
  end

  assign q_out = !dup_q ? map_one : (arr_q ? map_b : map_a);

  // Assertions
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R6: assert (q_out == '0);
    end
  end

  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a && cs_b) |=> $stable(q_out));

  assert_straight_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_a && cs_b) && !dup_mode) |=> (q_out == OW'($past(d_in))));

  assert_stacked_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_a && cs_b) && dup_mode && !arr_sel) |=>
      (q_out[NW-1:0] == $past(d_in[NW-1:0])) && (q_out[2*NW-1:NW] == $past(d_in[NW-1:0])));

  for (genvar k = 0; k < NW; k++) begin : g_chk_pair
    assert_paired_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cs_a && cs_b) && dup_mode && arr_sel) |=>
        (q_out[2*k] == $past(d_in[k])) && (q_out[2*k+1] == $past(d_in[k])));
  end

  assert_zero_in_zero_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_a && cs_b) && d_in == '0) |=> (q_out == '0));

endmodule

// File: tb/sim_fanout_reg.sv
`timescale 1ns/1ps
module sim_fanout_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dup_mode, arr_sel, cs_a, cs_b;
  logic [24:0] d_in;
  logic [27:0] q_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [24:0] m_d;
  logic        m_dup, m_arr;

  always #10 clk = ~clk;

  fanout_reg u0 (
    .clk(clk), .rst_n(rst_n), .dup_mode(dup_mode), .arr_sel(arr_sel),
    .cs_a(cs_a), .cs_b(cs_b), .d_in(d_in), .q_out(q_out)
  );

  function automatic logic [27:0] expmap(logic [24:0] d, logic dup, logic arr);
    logic [27:0] r;
    r = '0;
    if (!dup) r = {3'b000, d};
    else if (!arr) r = {d[13:0], d[13:0]};
    else for (int i = 0; i < 14; i++) begin
      r[2*i] = d[i];
      r[2*i+1] = d[i];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive, check no early change, clock, check result.
  task automatic cycle(string tag, logic [24:0] d, logic dup, logic arr, logic ca, logic cb);
    d_in = d; dup_mode = dup; arr_sel = arr; cs_a = ca; cs_b = cb;
    #2;
    chk({tag, " R1 pre-edge"}, q_out, expmap(m_d, m_dup, m_arr));
    @(posedge clk);
    if (!(ca && cb)) begin
      m_d = d; m_dup = dup; m_arr = arr;
    end
    @(negedge clk);
    chk(tag, q_out, expmap(m_d, m_dup, m_arr));
  endtask

  task automatic mid_reset(string tag, int hold_cycles, logic ca, logic cb);
    #4 rst_n = 1'b0;
    #1;
    chk({tag, " R6 immediate clear"}, q_out, '0);
    m_d = '0; m_dup = 1'b0; m_arr = 1'b0;
    for (int i = 0; i < hold_cycles; i++) begin
      d_in = $urandom; dup_mode = $urandom; arr_sel = $urandom; cs_a = ca; cs_b = cb;
      @(negedge clk);
      chk({tag, " R9 held in reset"}, q_out, '0);
    end
    d_in = '0;
    #7 rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_d = '0; m_dup = 1'b0; m_arr = 1'b0;
    rst_n = 1'b0; d_in = '0; dup_mode = 1'b0; arr_sel = 1'b0; cs_a = 1'b0; cs_b = 1'b0;
    #1;
    chk("R6 reset state", q_out, '0);
    @(negedge clk); @(negedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk);

    // R10: zero inputs after release keep outputs low
    for (int i = 0; i < 4; i++) cycle("R10 post-release zero", '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 straight mode
    cycle("R2 straight all ones", 25'h1FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle("R2 straight pattern", 25'h155_AA33, 1'b0, 1'b1, 1'b0, 1'b1);
    // R3 stacked
    cycle("R3 stacked", 25'h1AB_2C5D, 1'b1, 1'b0, 1'b1, 1'b0);
    cycle("R3 stacked walk", 25'h000_0001, 1'b1, 1'b0, 1'b0, 1'b0);
    // R4 paired
    cycle("R4 paired", 25'h000_2A55, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle("R4 paired top bit", 25'h000_2000, 1'b1, 1'b1, 1'b0, 1'b0);

    // R5 mode change between edges shows only after an edge (pre-edge check in cycle)
    cycle("R5 mode to straight", 25'h0F0_F0F0, 1'b0, 1'b1, 1'b0, 1'b0);
    cycle("R5 mode to paired", 25'h0F0_F0F0, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle("R5 layout to stacked", 25'h0F0_F0F0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7 freeze: data, mode and layout all ignored
    cycle("R7 freeze data", 25'h1FF_FFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    cycle("R7 freeze mode", 25'h000_0000, 1'b0, 1'b1, 1'b1, 1'b1);
    cycle("R8 release via cs_a low", 25'h123_4567, 1'b0, 1'b0, 1'b0, 1'b1);

    // R8 cs_b tied low: cs_a value irrelevant
    for (int i = 0; i < 12; i++)
      cycle("R8 cs_b low", 25'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);

    // R6 / R9 reset mid-cycle with freeze active
    cycle("R9 setup", 25'h1F0_0F0F, 1'b0, 1'b0, 1'b0, 1'b0);
    mid_reset("R9 reset over freeze", 3, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) cycle("R10 after second release", '0, 1'b1, 1'b1, 1'b0, 1'b0);

    cycle("R6 setup", 25'h0AA_AAAA, 1'b1, 1'b1, 1'b0, 1'b0);
    mid_reset("R6 reset normal", 2, 1'b0, 1'b0);
    cycle("R10 zero after release", '0, 1'b0, 1'b0, 1'b1, 1'b1);
    cycle("R10 zero capture", '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic ca, cb;
      ca = ($urandom % 2) == 1;
      cb = ($urandom % 3) == 0;
      cycle("R2/R3/R4/R7 random", 25'($urandom), 1'($urandom), 1'($urandom), ca, cb);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule